// File: doc/BRIEF.md
# Off-Hook Settling and Calibration Sequencer

This block walks a telephone line interface from an off-hook request to the moment its transmit and receive data paths may run. A request comes from a hardware pin or from a control bit. Either one starts a fixed timeline. The first step is a short command latency. Next comes a line-settling wait, whose length is picked from four values by a 2-bit select. After that come a resistor calibration phase and an ADC calibration phase, and each of these can be skipped. When every enabled phase has finished, the block raises a ready flag that gates the data paths.

All timing is counted in ticks of a clock-enable input. The defaults assume a 1 µs tick, so the latency is 250 ticks, the settle choices run from 8 ms to 512 ms, resistor calibration lasts 17 ms and ADC calibration lasts 256 ms. The calibration engines themselves sit outside the block. For each engine the sequencer gives a one-cycle start strobe and a busy level that lasts as long as that engine's fixed phase. Dropping the request sends the sequencer back to idle at once.

Top module: `offhook_seq`

## Requirements
- R1: An off-hook request is `hook_pin` OR `hook_bit`. Either one alone starts the sequence from idle.
- R2: The latency phase lasts exactly LAT_TICKS ticks.
- R3: The settle phase lasts a number of ticks set by `settle_sel`: 00 gives 128 ms (SET_00_TICKS), 01 gives 64 ms, 10 gives 8 ms and 11 gives 512 ms. The select is captured when the sequence leaves idle, and later changes to it have no effect on that run.
- R4: The resistor calibration phase lasts RCAL_TICKS ticks. It is skipped when `rcal_skip` is high at the end of the settle phase.
- R5: The ADC calibration phase lasts ADC_TICKS ticks. It is skipped when `adc_skip` is high at the moment it would start.
- R6: `path_ready` is high only in the ready phase, which is entered once all enabled phases have finished. The total time from request to ready is the sum of the enabled phase durations.
- R7: When the request drops in any phase, the very next clock edge gives the idle phase and `path_ready` low.
- R8: A phase advances only on cycles where `tick` is high. Cycles without a tick stretch the current phase by one cycle each.
- R9: `phase_o` encodes the phases as idle=0, latency=1, settle=2, resistor calibration=3, ADC calibration=4 and ready=5.
- R10: `rcal_start` and `adc_start` each pulse for a single cycle on entry to their phase. `rcal_busy` and `adc_busy` stay high for every cycle of that phase.
- R11: After reset the block is idle, with `path_ready`, the strobes and the busy levels all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase clock-enable (1 µs nominal) |
| hook_pin | input | 1 | Off-hook request from pin |
| hook_bit | input | 1 | Off-hook request from control bit |
| settle_sel | input | 2 | Settle-time select |
| rcal_skip | input | 1 | Skip resistor calibration |
| adc_skip | input | 1 | Skip ADC calibration |
| phase_o | output | 3 | Current phase code |
| path_ready | output | 1 | Data paths may run |
| rcal_start | output | 1 | Resistor calibration start strobe |
| rcal_busy | output | 1 | Resistor calibration phase active |
| adc_start | output | 1 | ADC calibration start strobe |
| adc_busy | output | 1 | ADC calibration phase active |

## Verification
The bench counts the cycles from request to ready for every settle code and every skip combination. A design that swapped two select codes or miscounted a phase by one shows up as a wrong total. The bench changes the select in the middle of a run: a design that reads the live select gives a different total. It drops the request in the middle of settling and again in ready, which catches a design that finishes its current phase first. It also withholds ticks for a stretch, so a design that counts clocks instead of ticks reaches ready too early.

// File: rtl/offhook_pkg.sv
package offhook_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_LAT    = 3'd1,
    PH_SETTLE = 3'd2,
    PH_RCAL   = 3'd3,
    PH_ADC    = 3'd4,
    PH_READY  = 3'd5
  } phase_t;
endpackage

// File: rtl/offhook_settle_lut.sv
module offhook_settle_lut #(
  parameter int W       = 19,
  parameter int T_00    = 128000,
  parameter int T_01    = 64000,
  parameter int T_10    = 8000,
  parameter int T_11    = 512000
) (
  input  logic [1:0]   code,
  output logic [W-1:0] ticks
);
  always_comb begin
    case (code)
      2'b00:   ticks = W'(T_00);
      2'b01:   ticks = W'(T_01);
      2'b10:   ticks = W'(T_10);
      default: ticks = W'(T_11);
    endcase
  end
endmodule

// File: rtl/offhook_phase_timer.sv
module offhook_phase_timer #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         expire
);
  logic [W-1:0] cnt;

  assign expire = tick && (cnt == limit - W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick)  cnt <= cnt + W'(1);
  end

  // R8: the count stays below the active limit
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    cnt < limit);
  // R8: no tick, no progress
  assert_hold_without_tick_R8: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(cnt));
endmodule

// File: rtl/offhook_cal_strobe.sv
module offhook_cal_strobe
  import offhook_pkg::*;
#(
  parameter phase_t TARGET = PH_RCAL
) (
  input  logic   clk,
  input  logic   rst,
  input  phase_t cur,
  input  phase_t nxt,
  output logic   start,
  output logic   busy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      start <= 1'b0;
      busy  <= 1'b0;
    end else begin
      start <= (nxt == TARGET) && (cur != TARGET);
      busy  <= (nxt == TARGET);
    end
  end

  // R10: a start strobe lasts one cycle
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);
  // R10: busy follows the phase it belongs to
  assert_busy_in_phase_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cur == TARGET));
endmodule

// File: rtl/offhook_seq.sv
module offhook_seq
  import offhook_pkg::*;
#(
  parameter int LAT_TICKS    = 250,
  parameter int SET_00_TICKS = 128000,
  parameter int SET_01_TICKS = 64000,
  parameter int SET_10_TICKS = 8000,
  parameter int SET_11_TICKS = 512000,
  parameter int RCAL_TICKS   = 17000,
  parameter int ADC_TICKS    = 256000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       hook_pin,
  input  logic       hook_bit,
  input  logic [1:0] settle_sel,
  input  logic       rcal_skip,
  input  logic       adc_skip,
  output logic [2:0] phase_o,
  output logic       path_ready,
  output logic       rcal_start,
  output logic       rcal_busy,
  output logic       adc_start,
  output logic       adc_busy
);
  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_T = max2(max2(max2(LAT_TICKS, SET_00_TICKS), max2(SET_01_TICKS, SET_10_TICKS)),
                              max2(max2(SET_11_TICKS, RCAL_TICKS), ADC_TICKS));
  localparam int CW    = $clog2(MAX_T + 1);

  phase_t         phase, phase_nxt;
  logic           req;
  logic [1:0]     sel_q;
  logic [CW-1:0]  settle_lim, limit;
  logic           expire, clr;

  assign req = hook_pin | hook_bit;

  offhook_settle_lut #(
    .W(CW), .T_00(SET_00_TICKS), .T_01(SET_01_TICKS),
    .T_10(SET_10_TICKS), .T_11(SET_11_TICKS)
  ) u_lut (
    .code  (sel_q),
    .ticks (settle_lim)
  );

  always_comb begin
    case (phase)
      PH_SETTLE: limit = settle_lim;
      PH_RCAL:   limit = CW'(RCAL_TICKS);
      PH_ADC:    limit = CW'(ADC_TICKS);
      default:   limit = CW'(LAT_TICKS);
    endcase
  end

  assign clr = (phase_nxt != phase) || (phase == PH_IDLE) || (phase == PH_READY);

  offhook_phase_timer #(.W(CW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .clr    (clr),
    .limit  (limit),
    .expire (expire)
  );

  always_comb begin
    phase_nxt = phase;
    case (phase)
      PH_IDLE:   if (req) phase_nxt = PH_LAT;
      PH_LAT:    if (expire) phase_nxt = PH_SETTLE;
      PH_SETTLE: if (expire) phase_nxt = rcal_skip ? (adc_skip ? PH_READY : PH_ADC) : PH_RCAL;
      PH_RCAL:   if (expire) phase_nxt = adc_skip ? PH_READY : PH_ADC;
      PH_ADC:    if (expire) phase_nxt = PH_READY;
      default:   phase_nxt = phase;
    endcase
    if (!req) phase_nxt = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      path_ready <= 1'b0;
      sel_q      <= 2'b00;
    end else begin
      phase      <= phase_nxt;
      path_ready <= (phase_nxt == PH_READY);
      if (phase == PH_IDLE && req) sel_q <= settle_sel;
    end
  end

  assign phase_o = phase;

  offhook_cal_strobe #(.TARGET(PH_RCAL)) u_rcal (
    .clk (clk), .rst (rst), .cur (phase), .nxt (phase_nxt),
    .start (rcal_start), .busy (rcal_busy)
  );

  offhook_cal_strobe #(.TARGET(PH_ADC)) u_adc (
    .clk (clk), .rst (rst), .cur (phase), .nxt (phase_nxt),
    .start (adc_start), .busy (adc_busy)
  );

  // R7: a dropped request returns to idle on the next edge
  assert_drop_to_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !req |=> (phase == PH_IDLE) && !path_ready);
  // R6: ready is only reached from a timed phase
  assert_ready_entry_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(path_ready) |-> ($past(phase) == PH_SETTLE || $past(phase) == PH_RCAL || $past(phase) == PH_ADC));
  // R4: resistor calibration is never entered while skipped
  assert_rcal_skip_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RCAL && $past(phase) == PH_SETTLE) |-> !$past(rcal_skip));
  // R5: ADC calibration is never entered while skipped
  assert_adc_skip_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ADC && $past(phase) != PH_ADC) |-> !$past(adc_skip));
  // R9: the phase code stays within the defined set
  assert_phase_code_R9: assert property (@(posedge clk) disable iff (rst)
    phase_o <= 3'd5);
endmodule

// File: tb/offhook_seq_tb.sv
`timescale 1ns/1ps
module offhook_seq_tb;
  localparam int LAT = 5, S00 = 24, S01 = 16, S10 = 8, S11 = 40, RC = 7, AD = 11;

  logic clk = 0, rst = 1, tick = 1, hook_pin = 0, hook_bit = 0;
  logic [1:0] settle_sel = 0;
  logic rcal_skip = 0, adc_skip = 0;
  logic [2:0] phase_o;
  logic path_ready, rcal_start, rcal_busy, adc_start, adc_busy;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  offhook_seq #(
    .LAT_TICKS(LAT), .SET_00_TICKS(S00), .SET_01_TICKS(S01),
    .SET_10_TICKS(S10), .SET_11_TICKS(S11), .RCAL_TICKS(RC), .ADC_TICKS(AD)
  ) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .hook_pin(hook_pin), .hook_bit(hook_bit),
    .settle_sel(settle_sel), .rcal_skip(rcal_skip), .adc_skip(adc_skip),
    .phase_o(phase_o), .path_ready(path_ready), .rcal_start(rcal_start),
    .rcal_busy(rcal_busy), .adc_start(adc_start), .adc_busy(adc_busy)
  );

  // {sel, rcal_skip, adc_skip, total ticks to ready}
  localparam logic [11:0] VECS [8] = '{
    {2'b00, 1'b0, 1'b0, 8'd47}, {2'b00, 1'b1, 1'b0, 8'd40},
    {2'b00, 1'b0, 1'b1, 8'd36}, {2'b00, 1'b1, 1'b1, 8'd29},
    {2'b01, 1'b0, 1'b0, 8'd39}, {2'b10, 1'b0, 1'b0, 8'd31},
    {2'b10, 1'b1, 1'b1, 8'd13}, {2'b11, 1'b0, 1'b0, 8'd63}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int settle_of(input logic [1:0] s);
    case (s)
      2'b00: return S00;
      2'b01: return S01;
      2'b10: return S10;
      default: return S11;
    endcase
  endfunction

  int n, c_lat, c_set, c_rc, c_ad, p_rc, p_ad, b_rc, b_ad;

  // Starts a run, optionally alters the select at cycle chg_at, withholds
  // ticks for gate_len cycles from gate_at, and counts edges until ready.
  task automatic run_seq(input logic [1:0] sel, input logic rs, input logic as_,
                         input logic by_pin, input int chg_at, input logic [1:0] chg_sel,
                         input int gate_at, input int gate_len);
    n = 0; c_lat = 0; c_set = 0; c_rc = 0; c_ad = 0; p_rc = 0; p_ad = 0; b_rc = 0; b_ad = 0;
    @(negedge clk);
    settle_sel = sel; rcal_skip = rs; adc_skip = as_; tick = 1;
    if (by_pin) hook_pin = 1; else hook_bit = 1;
    while (!path_ready && n < 400) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      case (phase_o)
        3'd1: c_lat++;
        3'd2: c_set++;
        3'd3: c_rc++;
        3'd4: c_ad++;
        default: ;
      endcase
      if (rcal_start) p_rc++;
      if (adc_start) p_ad++;
      if (rcal_busy) b_rc++;
      if (adc_busy) b_ad++;
      if (n == chg_at) settle_sel = chg_sel;
      tick = !(n >= gate_at && n < gate_at + gate_len);
    end
    tick = 1;
  endtask

  task automatic drop_and_check(input string tag);
    @(negedge clk);
    hook_pin = 0; hook_bit = 0;
    @(posedge clk);
    @(negedge clk);
    check({tag, " phase idle after drop"}, phase_o, 0);
    check({tag, " ready low after drop"}, path_ready, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check("R11 phase", phase_o, 0);
    check("R11 ready", path_ready, 0);
    check("R11 strobes", {rcal_start, rcal_busy, adc_start, adc_busy}, 0);
    rst = 0;

    // Table walk: R3 R4 R5 R6 R9 R10
    for (int i = 0; i < 8; i++) begin
      logic [1:0] s;
      logic r_s, a_s;
      s = VECS[i][11:10]; r_s = VECS[i][9]; a_s = VECS[i][8];
      run_seq(s, r_s, a_s, 1'b1, -1, 2'b00, -1, 0);
      check("R6 total to ready", n, int'(VECS[i][7:0]) + 1);
      check("R9 ready code", phase_o, 5);
      check("R2 latency cycles", c_lat, LAT);
      check("R3 settle cycles", c_set, settle_of(s));
      check("R4 rcal cycles", c_rc, r_s ? 0 : RC);
      check("R5 adc cycles", c_ad, a_s ? 0 : AD);
      check("R10 rcal start pulses", p_rc, r_s ? 0 : 1);
      check("R10 adc start pulses", p_ad, a_s ? 0 : 1);
      check("R10 rcal busy cycles", b_rc, r_s ? 0 : RC);
      check("R10 adc busy cycles", b_ad, a_s ? 0 : AD);
      drop_and_check("R7 ready");
    end

    // R1: control bit alone starts the sequence
    run_seq(2'b10, 1'b1, 1'b1, 1'b0, -1, 2'b00, -1, 0);
    check("R1 bit-only request", n, LAT + S10 + 1);
    drop_and_check("R7 bit");

    // R3: select change after leaving idle has no effect
    run_seq(2'b10, 1'b1, 1'b1, 1'b1, 3, 2'b11, -1, 0);
    check("R3 select latched", n, LAT + S10 + 1);
    drop_and_check("R7 latched");

    // R8: ticks withheld for 10 cycles stretch the run by 10
    run_seq(2'b10, 1'b1, 1'b1, 1'b1, -1, 2'b00, 7, 10);
    check("R8 tick gating", n, LAT + S10 + 1 + 10);
    drop_and_check("R7 gated");

    // R7: drop during settle
    @(negedge clk);
    settle_sel = 2'b00; hook_pin = 1;
    repeat (LAT + 4) @(negedge clk);
    check("R9 settle code", phase_o, 2);
    drop_and_check("R7 settle");
    check("R7 no strobe after drop", {rcal_busy, adc_busy}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule